// File: doc/BRIEF.md
# Two-Bank Byte-Lane Steering Controller

This block sits between a CPU-side request port and a 16-bit memory data bus. The memory behind that bus is built from two 8-bit banks. One bank holds the even-addressed bytes and uses the lower data lane. The other holds the odd-addressed bytes and uses the upper lane. Each request carries an address, a size (byte or word), a direction and write data. The controller turns it into one or two bus cycles with the right bank selects and lane placement, and answers with a single acknowledge.

Bank selection uses two active-low conditions. Address bit 0 low selects the even bank, and a separate high-lane enable low selects the odd bank. A word that starts at an odd address cannot use both lanes in one cycle. It is split into two single-byte cycles: the first at the odd address on the upper lane, the second at the next (even) address on the lower lane. On a read, the first byte is held in a register until the second cycle ends, and the word is then returned as a whole.

Each bus cycle lasts one clock. It begins on the clock after the request is accepted or after the previous cycle ends. Read data on the bus is sampled at the clock edge that ends the cycle.

Top module: `lane_ctrl`

## Requirements
- R1: After reset, `ack`, `bus_cyc`, `bus_we` and `busy` are 0 and `bus_hi_en_n` is 1.
- R2: A byte access at an even address makes exactly one bus cycle with `bus_addr` equal to the request address and `bus_hi_en_n`=1. A write places the byte on `bus_wdata[7:0]`. A read returns `{8'h00, bus_rdata[7:0]}`.
- R3: A byte access at an odd address makes exactly one bus cycle with `bus_addr` equal to the request address and `bus_hi_en_n`=0. A write copies the request's low byte onto `bus_wdata[15:8]`. A read returns `{8'h00, bus_rdata[15:8]}`.
- R4: A word access at an even address makes exactly one bus cycle with `bus_hi_en_n`=0. Request bits 7:0 travel on the lower lane and bits 15:8 on the upper lane, and a read returns `bus_rdata` unchanged.
- R5: A word access at an odd address X makes two bus cycles. The first is at X with `bus_hi_en_n`=0 and word bits 7:0 on the upper lane. The second is at X+1 (modulo the address width) with `bus_hi_en_n`=1 and word bits 15:8 on the lower lane.
- R6: A misaligned word read returns the upper lane of its first cycle in bits 7:0 and the lower lane of its second cycle in bits 15:8.
- R7: `ack` is high for exactly one clock, on the clock after the final bus cycle of a request. `rdata` is valid while `ack` is high.
- R8: A request is accepted only while `busy` is 0. `req_valid` seen while busy changes neither the bus cycles nor the result of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (a byte uses bits 7:0) |
| busy | output | 1 | Request in progress |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result, valid with ack |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | AW | Bus byte address; bit 0 low selects the even bank |
| bus_hi_en_n | output | 1 | Active-low odd-bank (upper lane) enable |
| bus_wdata | output | 16 | Write data on both lanes |
| bus_rdata | input | 16 | Read data from both lanes |

## Verification
The assertions assume the memory answers in the same cycle, with no wait states. They also assume that reset is applied before any request. The stimulus holds `req_valid` for one clock at a time while the block is idle. The one exception is a deliberate pulse during a split access, which checks that a request arriving while busy is ignored. Addresses, sizes and directions are drawn at random over a small 256-byte space, so that wrap-around at the top address and repeated reuse of locations both occur.

// File: rtl/lane_pkg.sv
package lane_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CYC1 = 2'd1,
        ST_CYC2 = 2'd2
    } lane_st_e;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned BUS_W  = 2 * LANE_W;
endpackage

// File: rtl/lane_plan.sv
module lane_plan
    import lane_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0]    addr,
    input  logic             word,
    input  logic             second,
    input  logic [BUS_W-1:0] wdata,
    output logic [AW-1:0]    cyc_addr,
    output logic             hi_en_n,
    output logic [BUS_W-1:0] lane_wdata
);
    logic [LANE_W-1:0] lo_b;
    logic [LANE_W-1:0] hi_b;

    assign lo_b = wdata[LANE_W-1:0];
    assign hi_b = wdata[BUS_W-1:LANE_W];

    always_comb begin
        cyc_addr   = second ? addr + AW'(1) : addr;
        hi_en_n    = 1'b1;
        lane_wdata = {lo_b, lo_b};
        if (!word) begin
            // single byte: odd bank only when bit 0 is set
            hi_en_n    = ~addr[0];
            lane_wdata = {lo_b, lo_b};
        end else if (!addr[0]) begin
            hi_en_n    = 1'b0;
            lane_wdata = wdata;
        end else if (!second) begin
            // misaligned first half: low byte rides the upper lane
            hi_en_n    = 1'b0;
            lane_wdata = {lo_b, lo_b};
        end else begin
            hi_en_n    = 1'b1;
            lane_wdata = {hi_b, hi_b};
        end
    end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import lane_pkg::*;
(
    input  logic              odd_addr,
    input  logic              word,
    input  logic              second,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic [LANE_W-1:0] held_lo,
    output logic [BUS_W-1:0]  merged
);
    always_comb begin
        if (second) begin
            merged = {bus_rdata[LANE_W-1:0], held_lo};
        end else if (word) begin
            merged = bus_rdata;
        end else if (odd_addr) begin
            merged = {{LANE_W{1'b0}}, bus_rdata[BUS_W-1:LANE_W]};
        end else begin
            merged = {{LANE_W{1'b0}}, bus_rdata[LANE_W-1:0]};
        end
    end
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
    import lane_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_word,
    input  logic             req_write,
    input  logic [15:0]      req_wdata,
    output logic             busy,
    output logic             ack,
    output logic [15:0]      rdata,
    output logic             bus_cyc,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_hi_en_n,
    output logic [15:0]      bus_wdata,
    input  logic [15:0]      bus_rdata
);
    typedef struct packed {
        lane_st_e          st;
        logic [AW-1:0]     addr;
        logic              word;
        logic              write;
        logic [BUS_W-1:0]  wdata;
        logic [LANE_W-1:0] held_lo;
        logic              cyc;
        logic              we;
        logic [AW-1:0]     baddr;
        logic              hi_n;
        logic [BUS_W-1:0]  bwdata;
        logic              ack;
        logic [BUS_W-1:0]  rdata;
    } ctrl_t;

    ctrl_t q, d;

    logic              idle;
    logic              split_q;
    logic [AW-1:0]     plan_addr_in;
    logic              plan_word_in;
    logic [BUS_W-1:0]  plan_wdata_in;
    logic              plan_second;
    logic [AW-1:0]     plan_addr;
    logic              plan_hi_n;
    logic [BUS_W-1:0]  plan_wdata;
    logic [BUS_W-1:0]  merged;

    assign idle    = (q.st == ST_IDLE);
    assign split_q = q.word & q.addr[0];

    assign plan_addr_in  = idle ? req_addr  : q.addr;
    assign plan_word_in  = idle ? req_word  : q.word;
    assign plan_wdata_in = idle ? req_wdata : q.wdata;
    assign plan_second   = (q.st == ST_CYC1);

    lane_plan #(.AW(AW)) u_plan (
        .addr       (plan_addr_in),
        .word       (plan_word_in),
        .second     (plan_second),
        .wdata      (plan_wdata_in),
        .cyc_addr   (plan_addr),
        .hi_en_n    (plan_hi_n),
        .lane_wdata (plan_wdata)
    );

    lane_merge u_merge (
        .odd_addr  (q.addr[0]),
        .word      (q.word),
        .second    (q.st == ST_CYC2),
        .bus_rdata (bus_rdata),
        .held_lo   (q.held_lo),
        .merged    (merged)
    );

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_CYC1;
                    d.addr   = req_addr;
                    d.word   = req_word;
                    d.write  = req_write;
                    d.wdata  = req_wdata;
                    d.cyc    = 1'b1;
                    d.we     = req_write;
                    d.baddr  = plan_addr;
                    d.hi_n   = plan_hi_n;
                    d.bwdata = plan_wdata;
                end
            end
            ST_CYC1: begin
                if (split_q) begin
                    d.st      = ST_CYC2;
                    d.held_lo = bus_rdata[BUS_W-1:LANE_W];
                    d.baddr   = plan_addr;
                    d.hi_n    = plan_hi_n;
                    d.bwdata  = plan_wdata;
                end else begin
                    d.st   = ST_IDLE;
                    d.ack  = 1'b1;
                    d.cyc  = 1'b0;
                    d.we   = 1'b0;
                    d.hi_n = 1'b1;
                    if (!q.write) d.rdata = merged;
                end
            end
            ST_CYC2: begin
                d.st   = ST_IDLE;
                d.ack  = 1'b1;
                d.cyc  = 1'b0;
                d.we   = 1'b0;
                d.hi_n = 1'b1;
                if (!q.write) d.rdata = merged;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.hi_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy        = ~idle;
    assign ack         = q.ack;
    assign rdata       = q.rdata;
    assign bus_cyc     = q.cyc;
    assign bus_we      = q.we;
    assign bus_addr    = q.baddr;
    assign bus_hi_en_n = q.hi_n;
    assign bus_wdata   = q.bwdata;

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_byte_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !q.word) |-> (bus_addr[0] != bus_hi_en_n));

    assert_odd_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && !bus_hi_en_n && bus_addr[0])
            |-> (bus_wdata[15:8] == q.wdata[7:0]));

    assert_even_word_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && q.word && !q.addr[0]) |-> (!bus_addr[0] && !bus_hi_en_n));

    assert_split_second_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CYC2) |-> (!bus_addr[0] && bus_hi_en_n && bus_cyc));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_cyc);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CYC1 && !split_q) |=> (q.st == ST_IDLE && ack));
endmodule

// File: tb/tb_lane_ctrl.sv
module tb_lane_ctrl;
    localparam int AW = 8;
    localparam int MS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_word = 1'b0;
    logic          req_write = 1'b0;
    logic [15:0]   req_wdata = '0;
    logic          busy, ack, bus_cyc, bus_we, bus_hi_en_n;
    logic [15:0]   rdata, bus_wdata, bus_rdata;
    logic [AW-1:0] bus_addr;

    logic [7:0] mem [MS];
    logic [7:0] ref_mem [MS];
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    lane_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .ack(ack), .rdata(rdata), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_hi_en_n(bus_hi_en_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // two-bank memory with zero-wait reads
    assign bus_rdata = {mem[{bus_addr[AW-1:1], 1'b1}], mem[{bus_addr[AW-1:1], 1'b0}]};

    always @(posedge clk) begin
        if (bus_cyc && bus_we) begin
            if (!bus_addr[0])  mem[{bus_addr[AW-1:1], 1'b0}] <= bus_wdata[7:0];
            if (!bus_hi_en_n)  mem[{bus_addr[AW-1:1], 1'b1}] <= bus_wdata[15:8];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input logic w);
        logic [AW-1:0] a1 = a + AW'(1);
        return w ? {ref_mem[a1], ref_mem[a]} : {8'h00, ref_mem[a]};
    endfunction

    task automatic do_req(input logic [AW-1:0] a, input logic w, input logic wr,
                          input logic [15:0] wd, input bit noise);
        int ncyc;
        int seen;
        bit got_ack;
        logic [AW-1:0] a1;
        logic [15:0] exp;
        string tag;
        a1   = a + AW'(1);
        ncyc = (w && a[0]) ? 2 : 1;
        tag  = !w ? (a[0] ? "R3" : "R2") : (a[0] ? "R5" : "R4");
        exp  = exp_read(a, w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = wd;
        seen = 0; got_ack = 1'b0;
        for (int i = 1; i <= 6 && !got_ack; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (noise && i == 1 && ncyc == 2) begin
                req_valid = 1'b1; req_addr = a + AW'(37); req_word = 1'b0;
                req_write = 1'b1; req_wdata = 16'hDEAD;
            end
            if (bus_cyc) begin
                seen++;
                if (seen == 1) begin
                    check(bus_addr == a, tag, 32'(bus_addr), 32'(a));
                    check(bus_hi_en_n == (w ? 1'b0 : ~a[0]), tag,
                          32'(bus_hi_en_n), 32'(w ? 1'b0 : ~a[0]));
                    check(bus_we == wr, tag, 32'(bus_we), 32'(wr));
                end else begin
                    check(bus_addr == a1 && bus_hi_en_n, "R5",
                          {bus_hi_en_n, 16'(bus_addr)}, {1'b1, 16'(a1)});
                end
            end
            if (ack) begin
                got_ack = 1'b1;
                check(i == ncyc + 1, "R7", 32'(i), 32'(ncyc + 1));
                check(seen == ncyc, noise ? "R8" : tag, 32'(seen), 32'(ncyc));
                if (!wr) check(rdata == exp, (w && a[0]) ? "R6" : tag, 32'(rdata), 32'(exp));
            end
        end
        check(got_ack, "R7", 32'(got_ack), 32'(1));
        req_valid = 1'b0;
        @(negedge clk);
        check(!ack && !busy, "R7", {ack, busy}, 0);
        if (wr) begin
            ref_mem[a] = wd[7:0];
            if (w) ref_mem[a1] = wd[15:8];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int mism;
        void'($urandom(32'h1A2B));
        for (int i = 0; i < MS; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        check(!ack && !bus_cyc && !bus_we && !busy && bus_hi_en_n, "R1",
              {ack, bus_cyc, bus_we, busy, bus_hi_en_n}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        do_req(8'h10, 1'b0, 1'b0, 16'h0, 1'b0);   // R2 even byte read
        do_req(8'h11, 1'b0, 1'b0, 16'h0, 1'b0);   // R3 odd byte read
        do_req(8'h20, 1'b1, 1'b1, 16'hBEEF, 1'b0); // R4 even word write
        do_req(8'h20, 1'b1, 1'b0, 16'h0, 1'b0);
        do_req(8'h21, 1'b0, 1'b1, 16'h0055, 1'b0); // R3 odd byte write
        do_req(8'h20, 1'b1, 1'b0, 16'h0, 1'b0);
        do_req(8'h33, 1'b1, 1'b1, 16'hA5C3, 1'b0); // R5 split write
        do_req(8'h33, 1'b1, 1'b0, 16'h0, 1'b1);   // R6 split read, R8 noise
        do_req(8'hFF, 1'b1, 1'b1, 16'h1234, 1'b0); // R5 wrap
        do_req(8'hFF, 1'b1, 1'b0, 16'h0, 1'b0);
        do_req(8'h00, 1'b0, 1'b0, 16'h0, 1'b0);
        for (int n = 0; n < 300; n++) begin
            do_req(AW'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                   1'($urandom));
        end
        mism = 0;
        for (int i = 0; i < MS; i++) if (mem[i] !== ref_mem[i]) mism++;
        check(mism == 0, "R2", 32'(mism), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule